// File: doc/BRIEF.md
# PLL Switchover Recovery Sequencer

This block is a control sequencer that sits next to a clock-synthesis PLL. It watches two per-input clock-fault flags, the PLL lock flag and the flag that says a reconfiguration has completed, and it drives three things: the PLL reset, the phase-detector enable and a set of output clock enables. When an input clock fails, it freezes the phase detector so the oscillator keeps its last frequency, and it gates the output clocks off. Once the faults clear, it pulses the PLL reset for a fixed minimum time and waits until lock has stayed high for a qualification window. Only then does it turn the outputs back on.

The same machine controls reconfiguration. A request made while the completion flag is low, with lock qualified, produces a one-cycle start strobe at once. A request made while the completion flag is still high from an earlier operation first resets the PLL, since that is the only way to clear the flag. The start is then held back until the synchronized flag has been seen low and lock is qualified again. All three PLL status inputs pass through a two-stage synchronizer before the machine uses them. The reset input `rst_n` is asynchronous and active-low and is expected to be released in step with `clk`.

Top module: `pll_recovery_seq`

## Requirements
- R1: While `rst_n` is low, `pll_areset` is 1, `clk_enable` is all zeros, `pfd_enable` is 1, `busy` is 1 and `reconfig_start` is 0.
- R2: When either bit of `clkbad_in` goes high, `pfd_enable` goes low at the third rising edge of `clk` (two synchronizer stages plus the state register). It stays low while any synchronized fault bit is high.
- R3: After the faults clear, and after a deferred reconfiguration request, `pll_areset` is high for exactly RST_CYCLES = ceil(RST_PULSE_PS / CLK_PERIOD_PS) cycles. With RST_PULSE_PS = 20000 and CLK_PERIOD_PS = 8000 this is 3.
- R4: `clk_enable` is all zeros whenever `pll_areset` is high or `pfd_enable` is low, and through the whole wait for lock that follows a reset pulse.
- R5: After a reset pulse, `clk_enable` becomes all ones at the (LOCK_STABLE + 3)-th rising edge after `pll_locked_in` rises, provided lock stays high. Any drop restarts the count from the next rise.
- R6: `busy` is 0 exactly when `clk_enable` is all ones, which is in the two running states, and 1 otherwise.
- R7: A `reconfig_req` sampled in a running state, with the synchronized done flag low and lock qualified, makes `reconfig_start` high for exactly one cycle, starting at the next rising edge.
- R8: A `reconfig_req` sampled while the synchronized done flag is high starts a reset pulse (R3) instead of a strobe. `reconfig_start` then waits until the synchronized done flag is low and lock is qualified, and it rises together with `clk_enable`. If done is the last condition to be met, the strobe comes at the third rising edge after `scandone_in` falls. If lock is the last, it comes one cycle later than the R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clkbad_in | input | 2 | Fault flags for PLL input clock 0 (bit 0) and 1 (bit 1), asynchronous |
| pll_locked_in | input | 1 | PLL lock flag, asynchronous |
| scandone_in | input | 1 | Reconfiguration-complete flag, asynchronous |
| reconfig_req | input | 1 | Request to start a reconfiguration, synchronous to clk |
| pll_areset | output | 1 | Reset to the PLL |
| pfd_enable | output | 1 | Phase-detector enable, low to hold the oscillator frequency |
| clk_enable | output | N_OUT | Per-output clock enables |
| reconfig_start | output | 1 | One-cycle strobe that starts a reconfiguration |
| busy | output | 1 | High while the sequencer is not in a running state |

## Verification
A behavioural PLL model in the bench drops lock on reset and raises it a few cycles later. It clears the done flag on reset, or holds it for a programmable time after reset, and it raises the flag after each start strobe. A fault on each input in turn separates a correct freeze from one that watches only one bit. A one-cycle lock glitch inside the qualification window separates lock-stability qualification from action on the first rising edge. Reconfiguration requests are tried with the done flag low, with it held well past lock, and with it cleared during the reset pulse. These three cases distinguish an immediate strobe, gating on done, and gating on lock.

// File: rtl/pllrec_pkg.sv
package pllrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE_RUN      = 3'd0,
    ST_FREEZE        = 3'd1,
    ST_RESET_PULSE   = 3'd2,
    ST_WAIT_LOCK     = 3'd3,
    ST_RUN           = 3'd4,
    ST_RECONFIG_WAIT = 3'd5
  } pllrec_state_e;

  // Whole clock cycles needed to cover a duration, rounded up, never zero.
  function automatic int unsigned cycles_for(input int unsigned dur_ps,
                                             input int unsigned per_ps);
    int unsigned c;
    c = (dur_ps + per_ps - 1) / per_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/pllrec_sync.sv
module pllrec_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= {stg_q[STAGES-2:0], din};
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pllrec_lock_qual.sv
module pllrec_lock_qual #(
  parameter int STABLE_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic lock_s,
  output logic stable
);

  localparam int CW = $clog2(STABLE_N + 1);

  logic [CW-1:0] run_q, run_d;
  logic          at_max;

  assign at_max = (run_q == CW'(STABLE_N));

  always_comb begin
    run_d = run_q;
    if (clr || !lock_s) begin
      run_d = '0;
    end else if (!at_max) begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      run_q <= run_d;
    end
  end

  assign stable = at_max;

endmodule

// File: rtl/pllrec_pulse_timer.sv
module pllrec_pulse_timer #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] tick_q, tick_d;

  assign last = (tick_q == CW'(LEN - 1));

  always_comb begin
    tick_d = '0;
    if (run && !last) begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end

endmodule

// File: rtl/pll_recovery_seq.sv
module pll_recovery_seq #(
  parameter int N_OUT         = 4,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int RST_PULSE_PS  = 10000,
  parameter int LOCK_STABLE   = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clkbad_in,
  input  logic             pll_locked_in,
  input  logic             scandone_in,
  input  logic             reconfig_req,
  output logic             pll_areset,
  output logic             pfd_enable,
  output logic [N_OUT-1:0] clk_enable,
  output logic             reconfig_start,
  output logic             busy
);

  import pllrec_pkg::*;

  localparam int RST_CYCLES = int'(cycles_for(RST_PULSE_PS, CLK_PERIOD_PS));
  localparam int NSYNC      = 4;

  logic [NSYNC-1:0] raw_in, sync_out;
  logic [1:0]       bad_s;
  logic             lock_s, done_s, bad_any;
  logic             lock_ok, pulse_last;
  pllrec_state_e    state_q, state_d;
  logic             pend_q, pend_d;
  logic             start_q, start_d;
  logic             running;

  assign raw_in = {scandone_in, pll_locked_in, clkbad_in};

  pllrec_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_in),
    .dout (sync_out)
  );

  assign bad_s   = sync_out[1:0];
  assign lock_s  = sync_out[2];
  assign done_s  = sync_out[3];
  assign bad_any = |bad_s;

  pllrec_lock_qual #(.STABLE_N(LOCK_STABLE)) u_lockq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q == ST_RESET_PULSE),
    .lock_s(lock_s),
    .stable(lock_ok)
  );

  pllrec_pulse_timer #(.LEN(RST_CYCLES)) u_ptmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_RESET_PULSE),
    .last (pulse_last)
  );

  // Next-state logic: a clock fault outranks every other condition.
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    start_d = 1'b0;
    if (bad_any) begin
      state_d = ST_FREEZE;
    end else begin
      unique case (state_q)
        ST_FREEZE: begin
          state_d = ST_RESET_PULSE;
        end
        ST_RESET_PULSE: begin
          if (pulse_last) state_d = ST_WAIT_LOCK;
        end
        ST_WAIT_LOCK: begin
          if (lock_ok) begin
            if (pend_q)      state_d = ST_RECONFIG_WAIT;
            else if (done_s) state_d = ST_RUN;
            else             state_d = ST_IDLE_RUN;
          end
        end
        ST_RECONFIG_WAIT: begin
          if (lock_ok && !done_s) begin
            start_d = 1'b1;
            pend_d  = 1'b0;
            state_d = ST_IDLE_RUN;
          end
        end
        ST_IDLE_RUN, ST_RUN: begin
          if (reconfig_req) begin
            if (done_s) begin
              pend_d  = 1'b1;
              state_d = ST_RESET_PULSE;
            end else if (lock_ok) begin
              start_d = 1'b1;
              state_d = ST_IDLE_RUN;
            end else begin
              pend_d  = 1'b1;
              state_d = ST_RECONFIG_WAIT;
            end
          end else begin
            state_d = done_s ? ST_RUN : ST_IDLE_RUN;
          end
        end
        default: begin
          state_d = ST_RESET_PULSE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET_PULSE;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      start_q <= start_d;
    end
  end

  assign running        = (state_q == ST_IDLE_RUN) || (state_q == ST_RUN);
  assign pll_areset     = (state_q == ST_RESET_PULSE);
  assign pfd_enable     = (state_q != ST_FREEZE);
  assign clk_enable     = {N_OUT{running}};
  assign busy           = !running;
  assign reconfig_start = start_q;

endmodule

// File: rtl/pllrec_seq_chk.sv
module pllrec_seq_chk #(
  parameter int N_OUT         = 4,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int RST_PULSE_PS  = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_areset,
  input logic             pfd_enable,
  input logic [N_OUT-1:0] clk_enable,
  input logic             busy,
  input logic             reconfig_start,
  input logic [1:0]       bad_s,
  input logic             done_s,
  input logic             lock_ok
);

  import pllrec_pkg::*;

  localparam int RSTC = int'(cycles_for(RST_PULSE_PS, CLK_PERIOD_PS));
  localparam int HW   = $clog2(RSTC + 1) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (!pll_areset) begin
      hi_cnt <= '0;
    end else if (hi_cnt < HW'(RSTC)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_freeze_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad_s) |=> !pfd_enable);

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_areset) |-> (hi_cnt >= HW'(RSTC)));

  assert_outputs_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_areset || !pfd_enable) |-> (clk_enable == '0));

  assert_freeze_no_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pfd_enable |-> !pll_areset);

  assert_busy_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (clk_enable != {N_OUT{1'b1}}));

  assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_start |=> !reconfig_start);

  assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconfig_start) |-> $past(!done_s && lock_ok));

endmodule

bind pll_recovery_seq pllrec_seq_chk #(
  .N_OUT        (N_OUT),
  .CLK_PERIOD_PS(CLK_PERIOD_PS),
  .RST_PULSE_PS (RST_PULSE_PS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pll_areset    (pll_areset),
  .pfd_enable    (pfd_enable),
  .clk_enable    (clk_enable),
  .busy          (busy),
  .reconfig_start(reconfig_start),
  .bad_s         (bad_s),
  .done_s        (done_s),
  .lock_ok       (lock_ok)
);

// File: tb/pll_recovery_seq_tb.sv
`timescale 1ns/1ps
module pll_recovery_seq_tb;

  localparam int CLK_NS   = 8;
  localparam int N_OUT    = 4;
  localparam int LOCK_N   = 16;
  localparam int RST_EXP  = 3;      // ceil(20000 / 8000)
  localparam int LOCK_DLY = 5;
  localparam int K_PFD = 1, K_ARST = 2, K_OE = 3, K_ST_RQ = 4, K_ST_DN = 5;

  typedef struct {
    int    kind;
    int    val;     // -1: value not checked
    string req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       clkbad_in;
  logic             pll_locked_in, scandone_in, reconfig_req;
  logic             pll_areset, pfd_enable, reconfig_start, busy;
  logic [N_OUT-1:0] clk_enable;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;
  bit glitch = 0;
  int done_hold = 0;

  always #(CLK_NS/2) clk = ~clk;

  pll_recovery_seq #(
    .N_OUT(N_OUT), .CLK_PERIOD_PS(8000), .RST_PULSE_PS(20000),
    .LOCK_STABLE(LOCK_N), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clkbad_in(clkbad_in),
    .pll_locked_in(pll_locked_in), .scandone_in(scandone_in),
    .reconfig_req(reconfig_req), .pll_areset(pll_areset),
    .pfd_enable(pfd_enable), .clk_enable(clk_enable),
    .reconfig_start(reconfig_start), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int val, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain(input int limit);
    int n = 0;
    while (q.size() > 0 && n < limit) begin
      @(posedge clk);
      n++;
    end
    if (q.size() > 0) begin
      check(0, q[0].req, "expected event never seen, kind", q[0].kind, q[0].kind);
      q.delete();
    end
  endtask

  // Behavioural PLL: lock follows reset release, done follows start strobe.
  initial begin
    int lk = 0, dcnt = 0, dh = 0;
    pll_locked_in = 0; scandone_in = 0;
    forever begin
      @(posedge clk); #2;
      if (pll_areset) begin
        lk = 0;
        if (done_hold == 0) scandone_in = 0; else dh = done_hold;
      end else begin
        if (lk < LOCK_DLY) lk++;
        if (dh > 0) begin
          dh--;
          if (dh == 0) scandone_in = 0;
        end
      end
      if (reconfig_start) dcnt = 4;
      else if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) scandone_in = 1;
      end
      pll_locked_in = (lk >= LOCK_DLY) && !glitch && !(|clkbad_in);
    end
  end

  // Monitor: measure event timings at the falling edge, compare with queue.
  int bad_c = 0, lk_c = 0, dn_c = 0, rq_c = 0, ar_w = 0;
  int v_r4 = 0, v_r6 = 0, st_hi = 0;
  logic p_pfd = 1, p_ar = 1, p_oe = 0, p_st = 0;

  task automatic observe(input int kind, input int val);
    if (q.size() == 0) begin
      check(0, "R2", "unexpected event kind", kind, 0);
    end else begin
      exp_t e = q.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      if (e.val >= 0) check(e.val == val, e.req, "event timing", val, e.val);
    end
  endtask

  always @(negedge clk) begin
    bad_c = (|clkbad_in) ? bad_c + 1 : 0;
    lk_c  = pll_locked_in ? lk_c + 1 : 0;
    dn_c  = !scandone_in ? dn_c + 1 : 0;
    rq_c  = reconfig_req ? 1 : ((rq_c > 0) ? rq_c + 1 : 0);
    ar_w  = pll_areset ? ar_w + 1 : ar_w;
    if (rst_n) begin
      if (clk_enable != '0 && (pll_areset || !pfd_enable)) v_r4++;
      if (busy != (clk_enable != {N_OUT{1'b1}})) v_r6++;
      st_hi = reconfig_start ? st_hi + 1 : 0;
      if (st_hi == 2) check(0, "R7", "start strobe width", 2, 1);
      if (p_pfd && !pfd_enable) observe(K_PFD, bad_c);
      if (p_ar && !pll_areset) begin
        observe(K_ARST, ar_w);
      end
      if (!p_oe && clk_enable == {N_OUT{1'b1}}) observe(K_OE, lk_c);
      if (!p_st && reconfig_start) begin
        if (q.size() > 0 && q[0].kind == K_ST_DN) observe(K_ST_DN, dn_c);
        else observe(K_ST_RQ, rq_c);
      end
    end
    if (!pll_areset) ar_w = 0;
    p_pfd = pfd_enable; p_ar = pll_areset;
    p_oe  = (clk_enable == {N_OUT{1'b1}}); p_st = reconfig_start;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R1", "watchdog expired, cycles", 100000, 0);
    summary();
  end

  initial begin
    rst_n = 0; clkbad_in = 2'b00; reconfig_req = 0;
    repeat (3) @(negedge clk);
    check(pll_areset == 1, "R1", "pll_areset in reset", pll_areset, 1);
    check(clk_enable == '0, "R1", "clk_enable in reset", clk_enable, 0);
    check(pfd_enable == 1, "R1", "pfd_enable in reset", pfd_enable, 1);
    check(busy == 1, "R1", "busy in reset", busy, 1);
    check(reconfig_start == 0, "R1", "reconfig_start in reset", reconfig_start, 0);

    // Bring-up: reset pulse, then lock qualification (R5).
    push(K_ARST, -1, "R3");
    push(K_OE, LOCK_N + 4, "R5");
    @(posedge clk); #1 rst_n = 1;
    drain(200);
    @(negedge clk);
    check(busy == 0, "R6", "busy when running", busy, 0);

    // Fault on input 0, lock glitch inside the qualification window.
    push(K_PFD, 4, "R2");
    push(K_ARST, RST_EXP, "R3");
    push(K_OE, LOCK_N + 4, "R5");
    @(posedge clk); #1 clkbad_in = 2'b01;
    repeat (12) @(posedge clk);
    #1 clkbad_in = 2'b00;
    wait (pll_areset == 1);
    wait (pll_areset == 0);
    wait (pll_locked_in == 1);
    repeat (8) @(posedge clk);
    #1 glitch = 1;
    @(posedge clk); #1 glitch = 0;
    drain(300);

    // Fault on input 1, clean recovery.
    push(K_PFD, 4, "R2");
    push(K_ARST, RST_EXP, "R4");
    push(K_OE, LOCK_N + 4, "R4");
    @(posedge clk); #1 clkbad_in = 2'b10;
    repeat (9) @(posedge clk);
    #1 clkbad_in = 2'b00;
    drain(300);

    // Request with done low: immediate strobe (R7).
    push(K_ST_RQ, 2, "R7");
    @(posedge clk); #1 reconfig_req = 1;
    @(posedge clk); #1 reconfig_req = 0;
    drain(50);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(scandone_in == 1 && busy == 0, "R6", "running with done high, busy", busy, 0);

    // Request with done high; done held long after reset: gated on done (R8).
    done_hold = 30;
    push(K_ARST, RST_EXP, "R8");
    push(K_OE, -1, "R8");
    push(K_ST_DN, 4, "R8");
    @(posedge clk); #1 reconfig_req = 1;
    @(posedge clk); #1 reconfig_req = 0;
    drain(300);
    repeat (10) @(posedge clk);

    // Request with done high; done cleared during reset: gated on lock (R8).
    done_hold = 0;
    push(K_ARST, RST_EXP, "R8");
    push(K_OE, LOCK_N + 5, "R8");
    push(K_ST_DN, -1, "R8");
    @(posedge clk); #1 reconfig_req = 1;
    @(posedge clk); #1 reconfig_req = 0;
    drain(300);
    repeat (5) @(posedge clk);

    check(v_r4 == 0, "R4", "cycles with outputs on during reset or freeze", v_r4, 0);
    check(v_r6 == 0, "R6", "cycles with busy mismatch", v_r6, 0);
    check(q.size() == 0, "R8", "leftover expected events", q.size(), 0);
    summary();
  end

endmodule